// File: doc/BRIEF.md
# Byte/Word Access Alignment Unit

This unit sits between a processor's load/store stage and a byte-addressed memory built from 16-bit words. Each cycle it takes one request: a pointer base, an access size (byte or word), a direction, and an address-update mode. From these it produces the effective address, the word address sent to memory, per-lane write enables and lane-replicated write data. It also produces the updated pointer, which moves by the operand size in bytes.

Read data comes back from a synchronous memory one cycle after the request. The unit returns full words unchanged. For a byte read it moves the addressed lane down to the low byte and clears the upper byte. A word access to an odd address is a fault. A faulting read still completes and returns the aligned word. A faulting write reaches memory with no lane enabled. In both cases a one-cycle trap request follows, carrying the direction and the faulting address. A second request port selector marks accesses from the dual-operand fetch path. That path is read-only and always fetches whole words.

Top module: `bw_access_aligner`

## Requirements
- R1: A byte read returns, on `rsp_rdata` in the cycle after the request, the memory lane chosen by effective-address bit 0 (0 = bits 7:0, 1 = bits 15:8) in bits 7:0, with bits 15:8 zero. `rsp_valid` is high in that cycle.
- R2: An aligned word read returns the whole memory word unchanged in the cycle after the request.
- R3: A byte write drives exactly one bit of `mem_we`: bit 0 for an even effective address, bit 1 for an odd one. The write byte appears in both lanes of `mem_wdata`. The other lane of the stored word is left unchanged.
- R4: An aligned word write drives `mem_we` = 2'b11 with `req_wdata` passed through unchanged.
- R5: A word write to an odd effective address drives `mem_we` = 0, so memory is unchanged. In the next cycle `trap_pulse` is 1, `trap_is_write` is 1 and `trap_addr` holds the effective address.
- R6: A word read to an odd effective address still completes. In the next cycle `rsp_valid` is 1 and `rsp_rdata` is the word at the address with bit 0 cleared. In the same cycle `trap_pulse` is 1, `trap_is_write` is 0 and `trap_addr` holds the effective address.
- R7: Mode codes for `req_mode`: 0 = plain, 1 = post-increment, 2 = post-decrement, 3 = pre-increment, 4 = pre-decrement, 5 to 7 = plain. Plain leaves `ptr_next` equal to the base. The modify modes move it by 1 for byte and 2 for word, wrapping modulo 2^16. Post modes access the unmodified base.
- R8: Pre modes use the modified pointer as the effective address, and `ptr_next` equals it.
- R9: With `req_ypath` = 1, the access is a word read whatever `req_size` and `req_write` say. `mem_we` is 0 and the step is 2.
- R10: `trap_pulse` is high only in the cycle after a misaligned request. It is low after aligned or byte accesses.
- R11: `mem_addr` is the effective address with bit 0 cleared, and `mem_en` follows `req_valid`.
- R12: After reset, `rsp_valid` and `trap_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 1 | 1 = word, 0 = byte |
| req_ypath | input | 1 | Dual-operand fetch path: word read only |
| req_mode | input | 3 | Address-update mode code |
| req_base | input | 16 | Pointer value before update |
| req_wdata | input | 16 | Store data (byte in bits 7:0) |
| ptr_next | output | 16 | Updated pointer value |
| mem_en | output | 1 | Memory access enable |
| mem_addr | output | 16 | Word-aligned byte address |
| mem_we | output | 2 | Per-lane write enables |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Memory read word, one cycle after `mem_en` |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Steered read data |
| trap_pulse | output | 1 | Address-error trap request |
| trap_is_write | output | 1 | Faulting access was a store |
| trap_addr | output | 16 | Faulting effective address |

## Verification
Each of the three registers that hold lane, size and pending state shows up at the ports within one cycle. A wrong stored lane puts the wrong byte on `rsp_rdata` in the response cycle. A lost size bit either zeroes the upper byte of a word read or leaves it uncleared on a byte read. A fault flag that stays set shows as a trap after the following aligned access. Errors in the enable or pointer logic are visible in the same cycle on `mem_we`, `mem_addr` and `ptr_next`. A bad write enable that damages the untouched lane is caught by the word read that follows each byte store.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    AM_PLAIN    = 3'd0,
    AM_POST_INC = 3'd1,
    AM_POST_DEC = 3'd2,
    AM_PRE_INC  = 3'd3,
    AM_PRE_DEC  = 3'd4
  } amode_e;
endpackage

// File: rtl/bwa_addr_gen.sv
module bwa_addr_gen #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        mode,
  input  logic              is_word,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] ptr_next,
  output logic              misaligned,
  output logic              is_pre
);
  import bwa_pkg::*;
  localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  // operand size in bytes
  function automatic logic [ADDR_W-1:0] size_step(input logic word);
    return word ? ADDR_W'(LANES) : ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] moved_ptr(input logic [ADDR_W-1:0] a,
                                                  input logic dec, input logic word);
    return dec ? (a - size_step(word)) : (a + size_step(word));
  endfunction

  logic              modifies, decrement;
  logic [ADDR_W-1:0] moved;

  always_comb begin
    modifies  = 1'b0;
    decrement = 1'b0;
    is_pre    = 1'b0;
    case (mode)
      AM_POST_INC: begin modifies = 1'b1; end
      AM_POST_DEC: begin modifies = 1'b1; decrement = 1'b1; end
      AM_PRE_INC:  begin modifies = 1'b1; is_pre = 1'b1; end
      AM_PRE_DEC:  begin modifies = 1'b1; is_pre = 1'b1; decrement = 1'b1; end
      default:     begin modifies = 1'b0; end
    endcase
  end

  assign moved      = moved_ptr(base, decrement, is_word);
  assign ea         = is_pre ? moved : base;
  assign ptr_next   = modifies ? moved : base;
  assign misaligned = is_word & (|ea[LSEL_W-1:0]);

  // R8: pre-modify accesses the updated pointer
  a_r8_pre_ea_is_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && is_pre) |-> (ea == ptr_next));

  // R7: post-modify and plain access the unmodified base
  a_r7_post_ea_is_base: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !is_pre) |-> (ea == base));

  // R7: a byte access never faults
  a_r7_byte_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !is_word) |-> !misaligned);
endmodule

// File: rtl/bwa_write_path.sv
module bwa_write_path #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          valid,
  input  logic                          is_write,
  input  logic                          is_word,
  input  logic                          misaligned,
  input  logic [((DATA_W/8 > 1) ? $clog2(DATA_W/8) : 1)-1:0] lane_sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W/8-1:0]           mem_we,
  output logic [DATA_W-1:0]             mem_wdata
);
  import bwa_pkg::*;
  localparam int unsigned LANES  = DATA_W / BYTE_W;
  localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic do_write;
  assign do_write = valid & is_write & ~misaligned;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mem_we[g] = do_write & (is_word | (lane_sel == LSEL_W'(g)));
    assign mem_wdata[g*BYTE_W +: BYTE_W] = is_word ? wdata[g*BYTE_W +: BYTE_W]
                                                   : wdata[BYTE_W-1:0];
  end

  // R3: a byte store enables exactly one lane
  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_write && !is_word) |-> ($countones(mem_we) == 1));

  // R5: a faulting store reaches memory with no lane enabled
  a_r5_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && misaligned) |-> (mem_we == '0));

  // R4: an aligned word store enables every lane
  a_r4_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_write && is_word && !misaligned) |-> (&mem_we));
endmodule

// File: rtl/bwa_read_steer.sv
module bwa_read_steer #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_fire,
  input  logic                          is_word,
  input  logic [((DATA_W/8 > 1) ? $clog2(DATA_W/8) : 1)-1:0] lane_sel,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata
);
  import bwa_pkg::*;
  localparam int unsigned LANES  = DATA_W / BYTE_W;
  localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              pend_word;
  logic [LSEL_W-1:0] pend_lane;
  logic [BYTE_W-1:0] byte_pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      pend_word <= 1'b0;
      pend_lane <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        pend_word <= is_word;
        pend_lane <= lane_sel;
      end
    end
  end

  always_comb begin
    byte_pick = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend_lane == LSEL_W'(i)) byte_pick = mem_rdata[i*BYTE_W +: BYTE_W];
    end
  end

  assign rsp_rdata = pend_word ? mem_rdata : {{(DATA_W-BYTE_W){1'b0}}, byte_pick};

  // R1: a byte response carries a zero upper part
  a_r1_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !pend_word) |-> (rsp_rdata[DATA_W-1:BYTE_W] == '0));

  // R2: a word response is the memory word as-is
  a_r2_word_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pend_word) |-> (rsp_rdata == mem_rdata));
endmodule

// File: rtl/bw_access_aligner.sv
module bw_access_aligner #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_size,
  input  logic                 req_ypath,
  input  logic [2:0]           req_mode,
  input  logic [ADDR_W-1:0]    req_base,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [ADDR_W-1:0]    ptr_next,
  output logic                 mem_en,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W/8-1:0]  mem_we,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 trap_pulse,
  output logic                 trap_is_write,
  output logic [ADDR_W-1:0]    trap_addr
);
  import bwa_pkg::*;
  localparam int unsigned LANES  = DATA_W / BYTE_W;
  localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  // named internal events
  logic              eff_word, eff_write, rd_fire, fault_now, is_pre;
  logic [ADDR_W-1:0] ea;
  logic              misaligned;
  logic [LSEL_W-1:0] lane_sel;

  assign eff_word  = req_size | req_ypath;
  assign eff_write = req_write & ~req_ypath;

  bwa_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
    .clk(clk), .rst_n(rst_n), .chk_valid(req_valid),
    .base(req_base), .mode(req_mode), .is_word(eff_word),
    .ea(ea), .ptr_next(ptr_next), .misaligned(misaligned), .is_pre(is_pre)
  );

  assign lane_sel  = ea[LSEL_W-1:0];
  assign fault_now = req_valid & misaligned;
  assign rd_fire   = req_valid & ~eff_write;
  assign mem_en    = req_valid;
  assign mem_addr  = {ea[ADDR_W-1:LSEL_W], {LSEL_W{1'b0}}};

  bwa_write_path #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .is_write(eff_write),
    .is_word(eff_word), .misaligned(misaligned), .lane_sel(lane_sel),
    .wdata(req_wdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  bwa_read_steer #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .is_word(eff_word),
    .lane_sel(lane_sel), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_pulse    <= 1'b0;
      trap_is_write <= 1'b0;
      trap_addr     <= '0;
    end else begin
      trap_pulse <= fault_now;
      if (fault_now) begin
        trap_is_write <= eff_write;
        trap_addr     <= ea;
      end
    end
  end

  // R10: a trap follows only a misaligned request
  a_r10_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> $past(req_valid && misaligned));

  // R6: a faulting read still produces a response
  a_r6_fault_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pulse && !trap_is_write) |-> rsp_valid);

  // R11: memory always sees a word-aligned address
  a_r11_mem_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[LSEL_W-1:0] == '0));

  // R9: the dual-operand path never writes
  a_r9_ypath_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ypath) |-> (mem_we == '0));

  // R1: a response follows a read request one cycle later
  a_r1_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && (mem_we == '0) && !(req_write && !req_ypath)));
endmodule

// File: tb/test_bw_access_aligner.sv
`timescale 1ns/1ps
module test_bw_access_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0, req_ypath = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic [15:0] req_base = '0, req_wdata = '0;
  logic [15:0] ptr_next, mem_addr, mem_wdata, rsp_rdata, trap_addr;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  mem_we;
  logic        mem_en, rsp_valid, trap_pulse, trap_is_write;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] mem [256];

  // observations from the last access
  logic [15:0] o_ptr, o_maddr, o_wdata, o_rsp, o_taddr;
  logic [1:0]  o_we;
  logic        o_rv, o_trap, o_tw;

  always #2.5 clk = ~clk;

  bw_access_aligner i_bw_access_aligner (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_ypath(req_ypath), .req_mode(req_mode),
    .req_base(req_base), .req_wdata(req_wdata), .ptr_next(ptr_next),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .trap_pulse(trap_pulse), .trap_is_write(trap_is_write), .trap_addr(trap_addr)
  );

  // synchronous memory model, one cycle read latency
  always @(posedge clk) begin
    if (mem_en) mem_rdata <= mem[mem_addr[8:1]];
    if (mem_we[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
    if (mem_we[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request; same-cycle outputs sampled mid-cycle, registered ones a cycle later
  task automatic access(input logic wr, input logic word, input logic yp,
                        input logic [2:0] md, input logic [15:0] base,
                        input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = word; req_ypath = yp;
    req_mode = md; req_base = base; req_wdata = wd;
    #1;
    o_ptr = ptr_next; o_maddr = mem_addr; o_we = mem_we; o_wdata = mem_wdata;
    @(negedge clk);
    o_rv = rsp_valid; o_rsp = rsp_rdata; o_trap = trap_pulse;
    o_tw = trap_is_write; o_taddr = trap_addr;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12", "rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk("R12", "trap_pulse", {15'd0, trap_pulse}, 16'd0);
  endtask

  task automatic t_word_rw();
    access(1, 1, 0, 3'd0, 16'h0010, 16'hA55A);
    chk("R4", "we", {14'd0, o_we}, 16'h0003);
    chk("R4", "wdata", o_wdata, 16'hA55A);
    chk("R11", "mem_addr", o_maddr, 16'h0010);
    chk("R10", "no trap", {15'd0, o_trap}, 16'd0);
    access(0, 1, 0, 3'd0, 16'h0010, 16'h0000);
    chk("R2", "rsp_valid", {15'd0, o_rv}, 16'd1);
    chk("R2", "rdata", o_rsp, 16'hA55A);
  endtask

  task automatic t_byte_write();
    access(1, 0, 0, 3'd0, 16'h0011, 16'h003C);
    chk("R3", "we odd", {14'd0, o_we}, 16'h0002);
    chk("R3", "wdata", o_wdata, 16'h3C3C);
    chk("R11", "odd byte mem_addr", o_maddr, 16'h0010);
    access(0, 1, 0, 3'd0, 16'h0010, 16'h0000);
    chk("R3", "low lane kept", o_rsp, 16'h3C5A);
    access(1, 0, 0, 3'd0, 16'h0010, 16'h1177);
    chk("R3", "we even", {14'd0, o_we}, 16'h0001);
    access(0, 1, 0, 3'd0, 16'h0010, 16'h0000);
    chk("R3", "high lane kept", o_rsp, 16'h3C77);
  endtask

  task automatic t_byte_read();
    access(0, 0, 0, 3'd0, 16'h0011, 16'h0000);
    chk("R1", "rsp_valid", {15'd0, o_rv}, 16'd1);
    chk("R1", "odd byte", o_rsp, 16'h003C);
    access(0, 0, 0, 3'd0, 16'h0010, 16'h0000);
    chk("R1", "even byte", o_rsp, 16'h0077);
  endtask

  task automatic t_mis_write();
    access(1, 1, 0, 3'd0, 16'h0012, 16'hBEEF);
    access(1, 1, 0, 3'd0, 16'h0013, 16'h1234);
    chk("R5", "we", {14'd0, o_we}, 16'h0000);
    chk("R5", "trap", {15'd0, o_trap}, 16'd1);
    chk("R5", "trap_is_write", {15'd0, o_tw}, 16'd1);
    chk("R5", "trap_addr", o_taddr, 16'h0013);
    access(0, 1, 0, 3'd0, 16'h0012, 16'h0000);
    chk("R5", "memory unchanged", o_rsp, 16'hBEEF);
    chk("R10", "trap cleared", {15'd0, o_trap}, 16'd0);
  endtask

  task automatic t_mis_read();
    access(0, 1, 0, 3'd0, 16'h0013, 16'h0000);
    chk("R6", "rsp_valid", {15'd0, o_rv}, 16'd1);
    chk("R6", "rdata", o_rsp, 16'hBEEF);
    chk("R6", "trap", {15'd0, o_trap}, 16'd1);
    chk("R6", "trap_is_write", {15'd0, o_tw}, 16'd0);
    chk("R6", "trap_addr", o_taddr, 16'h0013);
    access(0, 0, 0, 3'd0, 16'h0013, 16'h0000);
    chk("R10", "byte odd no trap", {15'd0, o_trap}, 16'd0);
    chk("R1", "odd byte of BEEF", o_rsp, 16'h00BE);
  endtask

  task automatic t_post();
    access(0, 0, 0, 3'd1, 16'h0020, 16'h0000);
    chk("R7", "post-inc byte ptr", o_ptr, 16'h0021);
    chk("R7", "post-inc byte addr", o_maddr, 16'h0020);
    access(0, 1, 0, 3'd1, 16'h0020, 16'h0000);
    chk("R7", "post-inc word ptr", o_ptr, 16'h0022);
    access(0, 0, 0, 3'd2, 16'h0020, 16'h0000);
    chk("R7", "post-dec byte ptr", o_ptr, 16'h001F);
    access(0, 1, 0, 3'd2, 16'h0000, 16'h0000);
    chk("R7", "post-dec word wrap", o_ptr, 16'hFFFE);
    chk("R7", "post-dec word addr", o_maddr, 16'h0000);
    access(0, 1, 0, 3'd0, 16'h0020, 16'h0000);
    chk("R7", "plain ptr", o_ptr, 16'h0020);
    access(0, 1, 0, 3'd6, 16'h0020, 16'h0000);
    chk("R7", "code 6 plain", o_ptr, 16'h0020);
  endtask

  task automatic t_pre();
    access(0, 1, 0, 3'd3, 16'h0010, 16'h0000);
    chk("R8", "pre-inc word ptr", o_ptr, 16'h0012);
    chk("R8", "pre-inc word addr", o_maddr, 16'h0012);
    chk("R8", "pre-inc word data", o_rsp, 16'hBEEF);
    access(0, 0, 0, 3'd4, 16'h0012, 16'h0000);
    chk("R8", "pre-dec byte ptr", o_ptr, 16'h0011);
    chk("R8", "pre-dec byte data", o_rsp, 16'h003C);
    access(0, 1, 0, 3'd3, 16'h0011, 16'h0000);
    chk("R8", "pre-inc odd trap", {15'd0, o_trap}, 16'd1);
    chk("R8", "pre-inc odd trap_addr", o_taddr, 16'h0013);
  endtask

  task automatic t_ypath();
    access(0, 0, 1, 3'd1, 16'h0010, 16'h0000);
    chk("R9", "word data", o_rsp, 16'h3C77);
    chk("R9", "word step", o_ptr, 16'h0012);
    access(1, 0, 1, 3'd0, 16'h0010, 16'h00FF);
    chk("R9", "no write", {14'd0, o_we}, 16'h0000);
    chk("R9", "read despite write", o_rsp, 16'h3C77);
    access(0, 1, 0, 3'd0, 16'h0010, 16'h0000);
    chk("R9", "memory unchanged", o_rsp, 16'h3C77);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_word_rw();
    t_byte_write();
    t_byte_read();
    t_mis_write();
    t_mis_read();
    t_post();
    t_pre();
    t_ypath();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule